// File: doc/BRIEF.md
# USB Remote Wakeup Signaling Timer

This block paces remote wakeup signaling on a USB device port. Software asks for a wakeup by writing 1 to a request bit. The block accepts the request only while the device is suspended and the host has allowed remote wakeup. It then waits until the bus has been idle for the minimum time and drives the K state for a fixed number of milliseconds. When the K state ends it releases the line and clears the request bit.

Idle time is counted in hardware from a 1 ms tick that is generated outside the block. Entering suspend is credited with the idle time that suspend detection has already seen. For that reason, a request written as suspend is detected waits only for the remaining part of the idle period. A request that arrives after the bus has already been idle long enough starts K without waiting for another tick. K is measured in whole ticks: the drive begins on a clock edge and ends on the edge of the final tick.

Top module: `usb_rwake_timer`

## Requirements
- R1: After a synchronous reset `drive_k` is 0 and `req_bit` is 0.
- R2: A write of 1 while `suspended` and `rwu_enabled` are both 1 and no K state is running sets `req_bit` on the next clock. A write of 0 while nothing is pending leaves `req_bit` at 0.
- R3: A write of 1 while `suspended` is 0 or `rwu_enabled` is 0 is ignored: `req_bit` and `drive_k` stay 0.
- R4: The rising edge of `suspended` counts as 3 ms of idle bus (parameter SUSP_MS). A request made at that edge starts K only after two more ticks, not after one.
- R5: Any cycle with `line_idle` at 0 restarts the idle count from zero, so a pending request then needs 5 more ticks of idle bus.
- R6: `drive_k` rises only after the idle count has reached 5 ms (IDLE_MS). If that time has already elapsed, K starts within two clocks of the write, with no tick needed.
- R7: The K state lasts 10 ticks (K_MS). `drive_k` stays 1 through the ninth tick counted while driving and falls on the clock edge of the tenth.
- R8: `req_bit` clears itself on the same edge at which `drive_k` falls. `drive_k` is never 1 while `req_bit` is 0.
- R9: While K is being driven, writes of 0 or 1 have no effect: `req_bit` stays 1 and the K length is unchanged.
- R10: If `suspended` falls while a request is waiting, the request is cancelled: `req_bit` clears on the next clock and K never starts. If K has already started, it runs its full length even when `suspended` falls.
- R11: A write of 0 while a request is waiting withdraws the request: `req_bit` clears and K does not start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the request bit |
| wr_data | input | 1 | Value written to the request bit |
| suspended | input | 1 | Device is in the suspended state |
| rwu_enabled | input | 1 | Host has enabled remote wakeup |
| line_idle | input | 1 | Bus is currently in the idle state |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| drive_k | output | 1 | Drive K state on the transceiver |
| req_bit | output | 1 | Readable wakeup request bit |

## Verification
The bench targets the credit given at the suspend edge. A design that ignores the credit would wait five ticks instead of two, and one that over-credits would start after a single tick. It also checks the tick on which K ends. An off-by-one in the K counter shows up as `drive_k` falling after the ninth or eleventh tick, and a design that does not clear the request bit itself leaves `req_bit` at 1 after K. Further cases are the loss of idle in mid-wait, which a design that keeps counting would ignore, and suspend dropping before and after K starts: one design keeps a stale request, another cuts K short. Writes during K are also tried, which a careless design would let clear the request or restart the count.

// File: rtl/usb_rwake_pkg.sv
package usb_rwake_pkg;

  typedef enum logic [1:0] {
    RW_IDLE  = 2'd0,
    RW_WAIT  = 2'd1,
    RW_DRIVE = 2'd2
  } rw_state_e;

  // Next idle count: cleared by activity, preloaded on suspend entry,
  // otherwise saturating increment on each millisecond tick.
  function automatic int unsigned idle_next(int unsigned cnt, int unsigned lim,
                                            int unsigned preload, logic busy,
                                            logic load, logic tick);
    if (busy)              return 0;
    if (load)              return preload;
    if (tick && cnt < lim) return cnt + 1;
    return cnt;
  endfunction

  // True when the tick being counted is the last one of the K interval.
  function automatic logic k_final(int unsigned cnt, int unsigned len, logic tick);
    return tick && (cnt == len - 1);
  endfunction

endpackage

// File: rtl/usb_rwake_idle_timer.sv
module usb_rwake_idle_timer #(
  parameter int unsigned IDLE_MS = 5,
  parameter int unsigned SUSP_MS = 3,
  localparam int unsigned IW     = $clog2(IDLE_MS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          suspended,
  input  logic          line_idle,
  input  logic          ms_tick,
  output logic [IW-1:0] idle_cnt,
  output logic          idle_ok,
  output logic          susp_rise
);
  import usb_rwake_pkg::*;

  logic susp_q;

  assign susp_rise = suspended && !susp_q;
  assign idle_ok   = (int'(idle_cnt) >= int'(IDLE_MS));

  always_ff @(posedge clk) begin
    if (rst) begin
      susp_q   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      susp_q   <= suspended;
      idle_cnt <= IW'(idle_next(int'(idle_cnt), IDLE_MS, SUSP_MS,
                                !line_idle, susp_rise, ms_tick));
    end
  end
endmodule

// File: rtl/usb_rwake_k_timer.sv
module usb_rwake_k_timer #(
  parameter int unsigned K_MS = 10,
  localparam int unsigned KW  = $clog2(K_MS)
) (
  input  logic clk,
  input  logic rst,
  input  logic driving,
  input  logic ms_tick,
  output logic k_last
);
  import usb_rwake_pkg::*;

  logic [KW-1:0] k_cnt;

  assign k_last = driving && k_final(int'(k_cnt), K_MS, ms_tick);

  always_ff @(posedge clk) begin
    if (rst || !driving) begin
      k_cnt <= '0;
    end else if (ms_tick && !k_last) begin
      k_cnt <= k_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/usb_rwake_ctrl.sv
module usb_rwake_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_data,
  input  logic suspended,
  input  logic rwu_enabled,
  input  logic idle_ok,
  input  logic k_last,
  output logic driving,
  output logic req_q
);
  import usb_rwake_pkg::*;

  rw_state_e state, state_n;
  logic      req_n;
  logic      accept;

  assign accept  = wr_en && wr_data && suspended && rwu_enabled;
  assign driving = (state == RW_DRIVE);

  always_comb begin
    state_n = state;
    req_n   = req_q;
    unique case (state)
      RW_IDLE: begin
        if (accept) begin
          state_n = RW_WAIT;
          req_n   = 1'b1;
        end
      end
      RW_WAIT: begin
        if (!suspended || (wr_en && !wr_data)) begin
          state_n = RW_IDLE;
          req_n   = 1'b0;
        end else if (idle_ok) begin
          state_n = RW_DRIVE;
        end
      end
      RW_DRIVE: begin
        if (k_last) begin
          state_n = RW_IDLE;
          req_n   = 1'b0;
        end
      end
      default: begin
        state_n = RW_IDLE;
        req_n   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RW_IDLE;
      req_q <= 1'b0;
    end else begin
      state <= state_n;
      req_q <= req_n;
    end
  end
endmodule

// File: rtl/usb_rwake_timer.sv
module usb_rwake_timer #(
  parameter int unsigned IDLE_MS = 5,
  parameter int unsigned SUSP_MS = 3,
  parameter int unsigned K_MS    = 10,
  localparam int unsigned IW     = $clog2(IDLE_MS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_data,
  input  logic suspended,
  input  logic rwu_enabled,
  input  logic line_idle,
  input  logic ms_tick,
  output logic drive_k,
  output logic req_bit
);
  logic [IW-1:0] idle_cnt;
  logic          idle_ok;
  logic          susp_rise;
  logic          k_last;
  logic          driving;

  usb_rwake_idle_timer #(.IDLE_MS(IDLE_MS), .SUSP_MS(SUSP_MS)) u_idle (
    .clk(clk), .rst(rst), .suspended(suspended), .line_idle(line_idle),
    .ms_tick(ms_tick), .idle_cnt(idle_cnt), .idle_ok(idle_ok),
    .susp_rise(susp_rise)
  );

  usb_rwake_k_timer #(.K_MS(K_MS)) u_k (
    .clk(clk), .rst(rst), .driving(driving), .ms_tick(ms_tick),
    .k_last(k_last)
  );

  usb_rwake_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .suspended(suspended), .rwu_enabled(rwu_enabled), .idle_ok(idle_ok),
    .k_last(k_last), .driving(driving), .req_q(req_bit)
  );

  assign drive_k = driving;
endmodule

// File: rtl/usb_rwake_timer_chk.sv
module usb_rwake_timer_chk #(
  parameter int unsigned IDLE_MS = 5,
  parameter int unsigned SUSP_MS = 3,
  localparam int unsigned IW     = $clog2(IDLE_MS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_data,
  input logic          suspended,
  input logic          rwu_enabled,
  input logic          line_idle,
  input logic          drive_k,
  input logic          req_bit,
  input logic [IW-1:0] idle_cnt,
  input logic          idle_ok,
  input logic          susp_rise,
  input logic          k_last
);
  // R8: the line is only driven while a request is held.
  p_drive_has_req_r8: assert property (@(posedge clk) disable iff (rst)
    drive_k |-> req_bit);

  // R3: writes outside suspend or without host permission do not set the bit.
  p_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data && !(suspended && rwu_enabled) && !req_bit) |=> !req_bit);

  // R6: K only starts once the idle time has been met.
  p_start_after_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_k) |-> $past(idle_ok));

  // R5: bus activity restarts the idle count.
  p_idle_restart_r5: assert property (@(posedge clk) disable iff (rst)
    !line_idle |=> (idle_cnt == '0));

  // R4: suspend entry preloads the idle credit.
  p_susp_credit_r4: assert property (@(posedge clk) disable iff (rst)
    (susp_rise && line_idle) |=> (int'(idle_cnt) == int'(SUSP_MS)));

  // R10: once started, K is held until its final tick.
  p_k_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (drive_k && !k_last) |=> drive_k);

  // R7: the final tick ends K and clears the request bit.
  p_k_end_r7: assert property (@(posedge clk) disable iff (rst)
    (drive_k && k_last) |=> (!drive_k && !req_bit));

  // R10: losing suspend before K cancels a waiting request.
  p_cancel_r10: assert property (@(posedge clk) disable iff (rst)
    (req_bit && !drive_k && !suspended) |=> !req_bit);
endmodule

bind usb_rwake_timer usb_rwake_timer_chk #(.IDLE_MS(IDLE_MS), .SUSP_MS(SUSP_MS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .suspended(suspended), .rwu_enabled(rwu_enabled), .line_idle(line_idle),
  .drive_k(drive_k), .req_bit(req_bit), .idle_cnt(idle_cnt),
  .idle_ok(idle_ok), .susp_rise(susp_rise), .k_last(k_last)
);

// File: tb/usb_rwake_timer_bench.sv
module usb_rwake_timer_bench;
  localparam int IDLE_MS = 5;
  localparam int SUSP_MS = 3;
  localparam int K_MS    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_data = 1'b0;
  logic suspended = 1'b0, rwu_enabled = 1'b0;
  logic line_idle = 1'b1, ms_tick = 1'b0;
  logic drive_k, req_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  usb_rwake_timer u_usb_rwake_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .suspended(suspended), .rwu_enabled(rwu_enabled), .line_idle(line_idle),
    .ms_tick(ms_tick), .drive_k(drive_k), .req_bit(req_bit)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic wr(logic v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 1'b0;
  endtask

  // Enter suspend with a request on the same edge; K starts after the
  // idle credit is topped up by IDLE_MS - SUSP_MS ticks.
  task automatic start_k();
    suspended = 1'b1; wr_en = 1'b1; wr_data = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 1'b0;
    for (int i = 0; i < IDLE_MS - SUSP_MS; i++) tick();
    cyc(2);
  endtask

  task automatic leave_suspend();
    suspended = 1'b0;
    cyc(3);
  endtask

  initial begin
    cyc(3);
    check("R1 drive_k after reset", drive_k, 1'b0);
    check("R1 req_bit after reset", req_bit, 1'b0);
    rst = 1'b0;
    cyc(2);

    // R3: host disabled, then not suspended
    suspended = 1'b1; rwu_enabled = 1'b0;
    cyc(2); wr(1'b1); cyc(1);
    check("R3 write ignored without host enable", req_bit, 1'b0);
    rwu_enabled = 1'b1; suspended = 1'b0;
    cyc(2); wr(1'b1);
    for (int i = 0; i < 6; i++) tick();
    check("R3 write ignored when not suspended", req_bit, 1'b0);
    check("R3 no K when not suspended", drive_k, 1'b0);

    // R2: write 0 from idle does nothing
    wr(1'b0);
    check("R2 write 0 leaves bit clear", req_bit, 1'b0);

    // R4 / R2: request at suspend edge, two-tick wait
    suspended = 1'b1; wr_en = 1'b1; wr_data = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 1'b0;
    check("R2 request accepted", req_bit, 1'b1);
    check("R4 no K before idle met", drive_k, 1'b0);
    tick(); cyc(2);
    check("R4 no K after one tick", drive_k, 1'b0);
    tick(); cyc(2);
    check("R4 K after second tick", drive_k, 1'b1);

    // R7 / R8: K length over the sweep of ticks
    for (int t = 1; t < K_MS; t++) begin
      tick();
      check("R7 K held before final tick", drive_k, 1'b1);
    end
    check("R8 bit held during K", req_bit, 1'b1);
    tick();
    check("R7 K ends on final tick", drive_k, 1'b0);
    check("R8 bit self-clears", req_bit, 1'b0);

    // R6: request long after idle met starts without a tick
    cyc(2);
    wr(1'b1); cyc(1);
    check("R6 prompt K start", drive_k, 1'b1);

    // R9: writes during K have no effect
    tick();
    wr(1'b0);
    check("R9 write 0 ignored during K", req_bit, 1'b1);
    wr(1'b1);
    for (int t = 2; t < K_MS; t++) tick();
    check("R9 K length unchanged", drive_k, 1'b1);
    tick();
    check("R9 K ends on schedule", drive_k, 1'b0);
    leave_suspend();

    // R5: line activity restarts idle count
    suspended = 1'b1; wr_en = 1'b1; wr_data = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 1'b0;
    tick();
    line_idle = 1'b0; cyc(1); line_idle = 1'b1; cyc(1);
    for (int t = 0; t < IDLE_MS - 1; t++) tick();
    cyc(2);
    check("R5 still waiting after 4 ticks", drive_k, 1'b0);
    tick(); cyc(2);
    check("R5 K after 5 idle ticks", drive_k, 1'b1);
    for (int t = 0; t < K_MS; t++) tick();
    check("R5 K finished", drive_k, 1'b0);
    leave_suspend();

    // R10: cancel before K
    suspended = 1'b1; wr_en = 1'b1; wr_data = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 1'b0;
    suspended = 1'b0; cyc(1);
    check("R10 waiting request cancelled", req_bit, 1'b0);
    for (int t = 0; t < 4; t++) tick();
    check("R10 no K after cancel", drive_k, 1'b0);

    // R11: write 0 withdraws a waiting request
    suspended = 1'b1; wr_en = 1'b1; wr_data = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 1'b0;
    wr(1'b0);
    check("R11 withdrawn request clear", req_bit, 1'b0);
    for (int t = 0; t < 4; t++) tick();
    check("R11 no K after withdraw", drive_k, 1'b0);
    leave_suspend();

    // R10: K survives loss of suspend
    start_k();
    check("R10 K started", drive_k, 1'b1);
    suspended = 1'b0;
    for (int t = 1; t < K_MS; t++) tick();
    check("R10 K continues after suspend drop", drive_k, 1'b1);
    tick();
    check("R10 K ends at full length", drive_k, 1'b0);
    check("R8 bit clear after K", req_bit, 1'b0);

    // R1: reset in the middle of K
    cyc(2);
    start_k();
    rst = 1'b1; cyc(1);
    check("R1 reset releases K", drive_k, 1'b0);
    check("R1 reset clears bit", req_bit, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule